// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block watches the instruction that is about to complete and compares its word address against two programmable breakpoint comparators. When an enabled comparator hits, the unit holds that instruction back from completing. In the same cycle it raises a one-cycle breakpoint exception request, and it records the instruction's word address in a save register.

Software reaches the comparator registers and a shared match-type control register through a single-cycle select/write-enable/data port. Accesses take effect only when the supervisor flag is high. An access made without privilege leaves all state untouched and raises an error pulse one cycle later.

Once an exception has been requested, a one-shot suppress flag is armed. The next instruction that completes is the tagged instruction being replayed after the handler returns. That instruction retires without matching again, and the flag then clears.

Top module: `ibrk_unit`

## Requirements
- R1: After reset, every register reads zero, and `save_addr`, `csr_err`, `cmt_stall` and `exc_req` are all low.
- R2: Select 0 addresses comparator 0 and select 1 addresses comparator 1. A privileged write stores `csr_wdata[31:2]` as the compare word address and `csr_wdata[1]` as the enable. On readback, bit 0 is always zero.
- R3: Select 2 addresses the control register. Bits [1:0] set the match type of comparator 0 and bits [3:2] set that of comparator 1 (00 equal, 01 less than, 10 greater-or-equal, 11 equal). Bit 4 is the combine bit. All other bits read as zero, and select 3 reads as zero.
- R4: An access with `csr_priv` low changes no register and returns zero read data. It makes `csr_err` high for exactly the following cycle. A privileged access gives no error.
- R5: While `cmt_valid` is high and an enabled comparator hits, `cmt_stall` and `exc_req` are high in that same cycle. `cmt_addr[1:0]` takes no part in the compare.
- R6: The less-than and greater-or-equal match types compare `cmt_addr[31:2]` as an unsigned word address against the stored address.
- R7: A comparator whose enable is clear never causes a hit, whatever its match type.
- R8: When the combine bit is set and both comparators are enabled, a hit needs both comparators to match, which forms an address range. If either comparator is disabled, the combine bit has no effect.
- R9: In the cycle after `exc_req`, `save_addr` holds the stalled instruction's address with bits [1:0] cleared. It keeps that value until the next exception.
- R10: After an exception, the next cycle with `cmt_valid` high completes without a stall, even when the address matches. Idle cycles in between keep this suppression armed. Matching resumes with the completion after that.
- R11: `exc_req` lasts exactly one cycle per exception, even when both comparators match at once.
- R12: With `cmt_valid` low, `cmt_stall` and `exc_req` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req | input | 1 | Register access this cycle |
| csr_we | input | 1 | Access is a write |
| csr_priv | input | 1 | Access is made in supervisor mode |
| csr_sel | input | 2 | Register select |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the selected register |
| csr_err | output | 1 | Unprivileged access error pulse |
| cmt_valid | input | 1 | An instruction is ready to complete |
| cmt_addr | input | 32 | Address of the instruction ready to complete |
| cmt_stall | output | 1 | Hold the instruction back from completing |
| exc_req | output | 1 | Breakpoint exception request pulse |
| save_addr | output | 32 | Captured address of the tagged instruction |

## Verification
The hardest condition to reach is the replay window. The suppress flag must survive several idle cycles after an exception and then be used up by exactly one completion at the same matching address. The following completion at that address must hit again. The stimulus reaches this state by firing a breakpoint, holding `cmt_valid` low for some cycles, and then presenting the same address twice. A behavioural model checks stall, request, saved address, error and read data on every clock. The same replay is also driven under less-than, greater-or-equal and combined range settings.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;

    typedef enum logic [1:0] {
        MT_EQ  = 2'b00,
        MT_LT  = 2'b01,
        MT_GE  = 2'b10,
        MT_EQX = 2'b11
    } mtype_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/ibrk_cmp.sv
module ibrk_cmp #(
    parameter int WA_W = 30
) (
    input  logic                       en,
    input  logic [ibrk_pkg::MODE_W-1:0] mode,
    input  logic [WA_W-1:0]            cea,
    input  logic [WA_W-1:0]            waddr,
    output logic                       hit
);
    import ibrk_pkg::*;

    logic rel;

    always_comb begin
        case (mtype_e'(mode))
            MT_LT:   rel = (waddr < cea);
            MT_GE:   rel = (waddr >= cea);
            default: rel = (waddr == cea);
        endcase
        hit = en & rel;
    end

endmodule

// File: rtl/ibrk_regs.sv
module ibrk_regs #(
    parameter  int AW    = 32,
    parameter  int NCMP  = 2,
    localparam int WA_W  = AW - 2,
    localparam int SEL_W = $clog2(NCMP + 1),
    localparam int MW    = ibrk_pkg::MODE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csr_req,
    input  logic                      csr_we,
    input  logic                      csr_priv,
    input  logic [SEL_W-1:0]          csr_sel,
    input  logic [AW-1:0]             csr_wdata,
    output logic [AW-1:0]             csr_rdata,
    output logic                      csr_err,
    output logic [NCMP-1:0][WA_W-1:0] cea_o,
    output logic [NCMP-1:0]           en_o,
    output logic [NCMP-1:0][MW-1:0]   mode_o,
    output logic                      comb_o
);

    typedef struct packed {
        logic [NCMP-1:0][WA_W-1:0] cea;
        logic [NCMP-1:0]           en;
        logic [NCMP-1:0][MW-1:0]   mode;
        logic                      comb;
        logic                      err;
    } regs_t;

    regs_t st_d, st_q;
    logic  acc_ok;

    always_comb begin
        st_d      = st_q;
        acc_ok    = csr_req & csr_priv;
        st_d.err  = csr_req & ~csr_priv;
        csr_rdata = '0;
        for (int i = 0; i < NCMP; i++) begin
            if (csr_sel == SEL_W'(i)) begin
                if (acc_ok && csr_we) begin
                    st_d.cea[i] = csr_wdata[AW-1:2];
                    st_d.en[i]  = csr_wdata[1];
                end
                if (acc_ok) begin
                    csr_rdata = {st_q.cea[i], st_q.en[i], 1'b0};
                end
            end
        end
        if (csr_sel == SEL_W'(NCMP)) begin
            if (acc_ok && csr_we) begin
                for (int i = 0; i < NCMP; i++) begin
                    st_d.mode[i] = csr_wdata[MW*i +: MW];
                end
                st_d.comb = csr_wdata[MW*NCMP];
            end
            if (acc_ok) begin
                for (int i = 0; i < NCMP; i++) begin
                    csr_rdata[MW*i +: MW] = st_q.mode[i];
                end
                csr_rdata[MW*NCMP] = st_q.comb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_err = st_q.err;
    assign cea_o   = st_q.cea;
    assign en_o    = st_q.en;
    assign mode_o  = st_q.mode;
    assign comb_o  = st_q.comb;

endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit #(
    parameter  int AW    = 32,
    parameter  int NCMP  = 2,
    localparam int WA_W  = AW - 2,
    localparam int SEL_W = $clog2(NCMP + 1),
    localparam int MW    = ibrk_pkg::MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_req,
    input  logic             csr_we,
    input  logic             csr_priv,
    input  logic [SEL_W-1:0] csr_sel,
    input  logic [AW-1:0]    csr_wdata,
    output logic [AW-1:0]    csr_rdata,
    output logic             csr_err,
    input  logic             cmt_valid,
    input  logic [AW-1:0]    cmt_addr,
    output logic             cmt_stall,
    output logic             exc_req,
    output logic [AW-1:0]    save_addr
);

    typedef struct packed {
        logic            sup;
        logic [WA_W-1:0] save;
    } trk_t;

    trk_t st_d, st_q;

    logic [NCMP-1:0][WA_W-1:0] cea;
    logic [NCMP-1:0]           en;
    logic [NCMP-1:0][MW-1:0]   mode;
    logic                      comb;
    logic [NCMP-1:0]           hit;
    logic [WA_W-1:0]           waddr;
    logic                      trig;
    logic                      fire;

    assign waddr = cmt_addr[AW-1:2];

    ibrk_regs #(.AW(AW), .NCMP(NCMP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_req   (csr_req),
        .csr_we    (csr_we),
        .csr_priv  (csr_priv),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .csr_err   (csr_err),
        .cea_o     (cea),
        .en_o      (en),
        .mode_o    (mode),
        .comb_o    (comb)
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        ibrk_cmp #(.WA_W(WA_W)) u_cmp (
            .en    (en[g]),
            .mode  (mode[g]),
            .cea   (cea[g]),
            .waddr (waddr),
            .hit   (hit[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (comb && (&en)) begin
            trig = &hit;
        end else begin
            trig = |hit;
        end
        fire = cmt_valid & trig & ~st_q.sup;
        if (fire) begin
            st_d.sup  = 1'b1;
            st_d.save = waddr;
        end else if (cmt_valid && st_q.sup) begin
            st_d.sup = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmt_stall = fire;
    assign exc_req   = fire;
    assign save_addr = {st_q.save, 2'b00};

endmodule

// File: rtl/ibrk_unit_chk.sv
module ibrk_unit_chk #(
    parameter  int AW    = 32,
    parameter  int NCMP  = 2,
    localparam int SEL_W = $clog2(NCMP + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_req,
    input logic             csr_priv,
    input logic [SEL_W-1:0] csr_sel,
    input logic [AW-1:0]    csr_rdata,
    input logic             csr_err,
    input logic             cmt_valid,
    input logic [AW-1:0]    cmt_addr,
    input logic             cmt_stall,
    input logic             exc_req,
    input logic [AW-1:0]    save_addr
);

    assert_bad_access_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_priv) |=> csr_err);

    assert_good_access_noerr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_req && !csr_priv) |=> !csr_err);

    assert_rsvd_bit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_sel < SEL_W'(NCMP)) |-> !csr_rdata[0]);

    assert_stall_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_valid |-> (!cmt_stall && !exc_req));

    assert_save_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (save_addr == {$past(cmt_addr[AW-1:2]), 2'b00}));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !exc_req);

    assert_save_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |=> $stable(save_addr));

    assert_save_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        save_addr[1:0] == 2'b00);

endmodule

bind ibrk_unit ibrk_unit_chk #(.AW(AW), .NCMP(NCMP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_req   (csr_req),
    .csr_priv  (csr_priv),
    .csr_sel   (csr_sel),
    .csr_rdata (csr_rdata),
    .csr_err   (csr_err),
    .cmt_valid (cmt_valid),
    .cmt_addr  (cmt_addr),
    .cmt_stall (cmt_stall),
    .exc_req   (exc_req),
    .save_addr (save_addr)
);

// File: tb/ibrk_unit_tb.sv
`timescale 1ns/1ps
module ibrk_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_req = 1'b0, csr_we = 1'b0, csr_priv = 1'b0;
    logic [1:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_err;
    logic        cmt_valid = 1'b0;
    logic [31:0] cmt_addr = '0;
    logic        cmt_stall, exc_req;
    logic [31:0] save_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ibrk_unit u_dut (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
        .csr_priv(csr_priv), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .csr_err(csr_err), .cmt_valid(cmt_valid),
        .cmt_addr(cmt_addr), .cmt_stall(cmt_stall), .exc_req(exc_req),
        .save_addr(save_addr)
    );

    // behavioural model state
    logic [29:0] m_cea [2];
    bit          m_en  [2];
    int          m_mode[2];
    bit          m_comb, m_sup, m_err;
    logic [31:0] m_save;

    function automatic bit m_match(int i, logic [31:0] a);
        longint unsigned w = longint'(a) / 4;
        longint unsigned c = longint'(m_cea[i]);
        if (!m_en[i]) return 0;
        if (m_mode[i] == 1) return w < c;
        if (m_mode[i] == 2) return w >= c;
        return w == c;
    endfunction

    function automatic bit m_fire(bit v, logic [31:0] a);
        bit h0 = m_match(0, a);
        bit h1 = m_match(1, a);
        bit t  = (m_comb && m_en[0] && m_en[1]) ? (h0 && h1) : (h0 || h1);
        return v && t && !m_sup;
    endfunction

    function automatic logic [31:0] m_read(bit rq, bit pv, int s);
        if (!(rq && pv)) return 32'h0;
        if (s < 2) return {m_cea[s], m_en[s], 1'b0};
        if (s == 2) return 32'(m_mode[0]) | (32'(m_mode[1]) << 2) | (32'(m_comb) << 4);
        return 32'h0;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit rq, bit we, bit pv, int s, logic [31:0] wd,
                        bit v, logic [31:0] a);
        bit f;
        @(negedge clk);
        csr_req = rq; csr_we = we; csr_priv = pv; csr_sel = 2'(s); csr_wdata = wd;
        cmt_valid = v; cmt_addr = a;
        #1;
        f = m_fire(v, a);
        chk(tag, "cmt_stall", 32'(cmt_stall), 32'(f));
        chk(tag, "exc_req", 32'(exc_req), 32'(f));
        chk(tag, "csr_rdata", csr_rdata, m_read(rq, pv, s));
        chk(tag, "csr_err", 32'(csr_err), 32'(m_err));
        chk(tag, "save_addr", save_addr, m_save);
        @(posedge clk);
        m_err = rq && !pv;
        if (rq && pv && we) begin
            if (s < 2) begin
                m_cea[s] = wd[31:2];
                m_en[s]  = wd[1];
            end else if (s == 2) begin
                m_mode[0] = int'(wd[1:0]);
                m_mode[1] = int'(wd[3:2]);
                m_comb    = wd[4];
            end
        end
        if (f) begin
            m_sup  = 1;
            m_save = {a[31:2], 2'b00};
        end else if (v && m_sup) begin
            m_sup = 0;
        end
    endtask

    task automatic wr(string tag, int s, logic [31:0] d);
        step(tag, 1, 1, 1, s, d, 0, 0);
    endtask
    task automatic rd(string tag, int s);
        step(tag, 1, 0, 1, s, 0, 0, 0);
    endtask
    task automatic cm(string tag, logic [31:0] a);
        step(tag, 0, 0, 0, 0, 0, 1, a);
    endtask
    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_cea[i] = '0; m_en[i] = 0; m_mode[i] = 0;
        end
        m_comb = 0; m_sup = 0; m_err = 0; m_save = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd("R1", 0); rd("R1", 1); rd("R1", 2); idle("R1");

        // R2: breakpoint register format, bit 0 reads zero
        wr("R2", 0, 32'h0000_1003);
        rd("R2", 0);
        wr("R2", 1, 32'hFFFF_FFFD);
        rd("R2", 1);
        wr("R2", 1, 32'h0);

        // R3: control register fields and unused select
        wr("R3", 2, 32'hFFFF_FFFF);
        rd("R3", 2);
        rd("R3", 3);
        wr("R3", 2, 32'h0);
        rd("R3", 2);

        // R4: unprivileged accesses are ignored and flag an error
        step("R4", 1, 1, 0, 1, 32'h0000_2002, 0, 0);
        step("R4", 1, 0, 0, 0, 0, 0, 0);
        rd("R4", 1);
        idle("R4");

        // R5 and R9: equal hit with low address bits set
        cm("R5", 32'h0000_0FFC);
        cm("R5", 32'h0000_1001);
        // R10: suppression survives idle cycles, then one completion uses it
        idle("R10"); idle("R10"); idle("R10");
        cm("R10", 32'h0000_1000);
        cm("R10", 32'h0000_1000);
        cm("R10", 32'h0000_1003);
        idle("R9");

        // R7: disabled comparator with less-than type never hits
        wr("R7", 1, 32'h0000_2000);
        wr("R7", 2, 32'h0000_0004);
        cm("R7", 32'h0000_0000);
        cm("R7", 32'h0000_1FFC);

        // R6: less-than, then greater-or-equal on comparator 0
        wr("R6", 2, 32'h0000_0001);
        cm("R6", 32'h0000_1000);
        cm("R6", 32'h0000_0FFC);
        cm("R6", 32'h0000_0FF8);
        cm("R6", 32'h0000_0FF8);
        wr("R6", 2, 32'h0000_0002);
        cm("R6", 32'h0000_0FFC);
        cm("R6", 32'h0000_8000);
        cm("R6", 32'h0000_8004);

        // R8: range [0x1000, 0x2000) with combine
        wr("R8", 1, 32'h0000_2002);
        wr("R8", 2, 32'h0000_0016);
        cm("R8", 32'h0000_0800);
        cm("R8", 32'h0000_2000);
        cm("R8", 32'h0000_1800);
        cm("R8", 32'h0000_1800);
        cm("R8", 32'h0000_1FFC);
        idle("R8");
        // combine ignored when comparator 1 disabled
        wr("R8", 1, 32'h0000_2000);
        cm("R8", 32'h0000_2000);
        cm("R8", 32'h0000_3000);

        // R11: both comparators equal on the same address, single pulse
        wr("R11", 0, 32'h0000_4002);
        wr("R11", 1, 32'h0000_4002);
        wr("R11", 2, 32'h0000_0000);
        cm("R11", 32'h0000_4000);
        cm("R11", 32'h0000_4000);
        cm("R11", 32'h0000_4000);

        // R12: no valid completion, no stall; write and compare together
        idle("R12");
        step("R12", 0, 0, 0, 0, 0, 0, 32'h0000_4000);
        step("R12", 1, 1, 1, 0, 32'h0000_5002, 1, 32'h0000_5000);
        cm("R12", 32'h0000_5000);
        idle("R12");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule